// File: doc/BRIEF.md
# Selectable-Ratio Complex Decimation Chain

This block takes a complex baseband sample stream, with in-phase and quadrature lanes, that arrives at a selectable number of samples per symbol. It brings the stream down to two samples per symbol for the matched filter that follows. The chain has four stages in a fixed order: a plain keep-one-in-two sample dropper, two half-band decimate-by-2 filters, and a polyphase resampler that emits two samples for every three it receives. A gain stage at the end removes the extra gain that the resampler adds. A three-bit ratio select input decides which stages are active. A stage that is switched off is a wire for both data and strobe.

Samples enter with an input strobe and leave with an output strobe, and there is no backpressure. Any change of the ratio select clears every delay line, phase counter and pending output. The stream under the new setting therefore starts from a clean state.

Top module: `dcm_chain`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is low.
- R2: The ratio select code picks the active stages. Code 0 (ratio 2) enables none. Code 1 (ratio 3) enables the resampler. Code 2 (ratio 4) enables half-band A. Code 3 (ratio 6) enables half-band A and the resampler. Code 4 (ratio 8) enables both half-bands. Code 5 (ratio 12) enables the dropper, half-band A and the resampler. Code 6 (ratio 16) enables the dropper and both half-bands. Code 7 behaves as code 0. The output sample count is the input count times 2/ratio.
- R3: When enabled, the dropper forwards the 1st, 3rd, 5th and later odd-numbered samples counted since the last clear, and discards the others.
- R4: An enabled half-band holds the current input x[n] and the six before it. After every 2nd, 4th and later even-numbered input it emits (16·x[n−3] + 9·(x[n−2]+x[n−4]) − x[n] − x[n−6]) arithmetically shifted right by 5 (floor). Taps never written since the last clear read as zero.
- R5: The enabled resampler counts inputs in groups of three and emits nothing for the first input of a group. On the 2nd input it emits (2·x[n]+12·x[n−1]+8·x[n−2]+2·x[n−3])>>>4. On the 3rd input it emits (2·x[n]+8·x[n−1]+12·x[n−2]+2·x[n−3])>>>4. Taps clear to zero.
- R6: When the resampler is enabled, the gain stage outputs (11·v)>>>4 (floor). When it is not, the gain stage outputs v unchanged.
- R7: A disabled stage passes samples and strobe unchanged, so code 0 reproduces the input stream exactly.
- R8: A change of the ratio select clears all stage state. A sample presented in the same cycle as the change is discarded. The cycle after a change has `out_valid` low.
- R9: Each filter result and the gain result saturate to the signed W-bit range [−2^(W−1), 2^(W−1)−1].
- R10: The I and Q lanes pass through identical, independent arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Ratio select code (R2) |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | In-phase input, signed |
| in_q | input | W | Quadrature input, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | W | In-phase output, signed |
| out_q | output | W | Quadrature output, signed |

## Verification
The bench drives every ratio code, including the spare code 7, with random samples and random gaps in the strobe. Full-scale alternating and constant extremes are driven into the resampler and half-band modes. A design with a wrong tap or a missing clip would then wrap to the opposite sign rather than pin at the rail. Short odd-length bursts followed by a mode change check the flush. A chain that kept stale taps or a stale phase would put the wrong values or the wrong count in the next stream. A sample presented in the cycle of a mode change must not appear at the output. A swapped half-band output phase or resampler phase would shift every result by one input.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

   localparam int HB_HIST  = 6;   // stored half-band history, x[n-1..n-6]
   localparam int RS_HIST  = 3;   // stored resampler history, x[n-1..n-3]
   localparam int GUARD    = 6;   // accumulator growth bits
   localparam int NLANE    = 2;   // I and Q

   typedef enum logic [2:0] {
      OSR_2  = 3'd0,
      OSR_3  = 3'd1,
      OSR_4  = 3'd2,
      OSR_6  = 3'd3,
      OSR_8  = 3'd4,
      OSR_12 = 3'd5,
      OSR_16 = 3'd6
   } osr_e;

   typedef struct packed {
      logic drop;
      logic hb_a;
      logic hb_b;
      logic rs;
   } stage_en_t;

   function automatic stage_en_t decode_mode(input logic [2:0] m);
      stage_en_t e;
      e = '0;
      case (osr_e'(m))
         OSR_3:  e.rs = 1'b1;
         OSR_4:  e.hb_a = 1'b1;
         OSR_6:  begin e.hb_a = 1'b1; e.rs = 1'b1; end
         OSR_8:  begin e.hb_a = 1'b1; e.hb_b = 1'b1; end
         OSR_12: begin e.drop = 1'b1; e.hb_a = 1'b1; e.rs = 1'b1; end
         OSR_16: begin e.drop = 1'b1; e.hb_a = 1'b1; e.hb_b = 1'b1; end
         default: e = '0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/dcm_drop2.sv
module dcm_drop2 #(
   parameter int W   = 12,
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    flush,
   input  logic                    in_vld,
   input  logic [NCH-1:0][W-1:0]   in_d,
   output logic                    out_vld,
   output logic [NCH-1:0][W-1:0]   out_d
);

   if (W < 4) begin : g_bad_w
      $error("dcm_drop2: W must be at least 4");
   end

   logic                  odd_q;
   logic                  vld_q;
   logic [NCH-1:0][W-1:0] dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         odd_q <= 1'b0;
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (en && in_vld) begin
         odd_q <= ~odd_q;
         vld_q <= ~odd_q;
         if (!odd_q) dat_q <= in_d;
      end else begin
         vld_q <= 1'b0;
      end
   end

   assign out_vld = en ? vld_q : in_vld;
   assign out_d   = en ? dat_q : in_d;

   assert_drop_alt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);

endmodule

// File: rtl/dcm_halfband.sv
module dcm_halfband #(
   parameter int W   = 12,
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    flush,
   input  logic                    in_vld,
   input  logic [NCH-1:0][W-1:0]   in_d,
   output logic                    out_vld,
   output logic [NCH-1:0][W-1:0]   out_d
);
   import dcm_pkg::*;

   localparam int AW = W + GUARD;
   localparam int NT = HB_HIST;
   localparam logic signed [AW-1:0] HI = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [AW-1:0] LO = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

   if (W < 4) begin : g_bad_w
      $error("dcm_halfband: W must be at least 4");
   end

   function automatic logic signed [AW-1:0] sx(input logic [W-1:0] v);
      return AW'($signed(v));
   endfunction

   function automatic logic [W-1:0] clip(input logic signed [AW-1:0] v);
      if (v > HI)      return HI[W-1:0];
      else if (v < LO) return LO[W-1:0];
      else             return v[W-1:0];
   endfunction

   // x0 newest, x2/x4 side taps, x3 centre, x6 oldest
   function automatic logic [W-1:0] hb_calc(input logic [W-1:0] x0, input logic [W-1:0] x2,
                                            input logic [W-1:0] x3, input logic [W-1:0] x4,
                                            input logic [W-1:0] x6);
      logic signed [AW-1:0] acc;
      acc = (sx(x3) <<< 4) + (sx(x2) <<< 3) + sx(x2) + (sx(x4) <<< 3) + sx(x4)
            - sx(x0) - sx(x6);
      return clip(acc >>> 5);
   endfunction

   logic [NCH-1:0][NT-1:0][W-1:0] tap_q;
   logic                          ph_q;
   logic                          vld_q;
   logic [NCH-1:0][W-1:0]         dat_q;
   logic [NCH-1:0][W-1:0]         res;

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         res[c] = hb_calc(in_d[c], tap_q[c][1], tap_q[c][2], tap_q[c][3], tap_q[c][5]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         tap_q <= '0;
         ph_q  <= 1'b0;
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (en && in_vld) begin
         for (int c = 0; c < NCH; c++) begin
            tap_q[c] <= {tap_q[c][NT-2:0], in_d[c]};
         end
         ph_q  <= ~ph_q;
         vld_q <= ph_q;
         if (ph_q) dat_q <= res;
      end else begin
         vld_q <= 1'b0;
      end
   end

   assign out_vld = en ? vld_q : in_vld;
   assign out_d   = en ? dat_q : in_d;

   assert_hb_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
   assert_hb_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(in_vld && en));

endmodule

// File: rtl/dcm_resamp32.sv
module dcm_resamp32 #(
   parameter int W   = 12,
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    flush,
   input  logic                    in_vld,
   input  logic [NCH-1:0][W-1:0]   in_d,
   output logic                    out_vld,
   output logic [NCH-1:0][W-1:0]   out_d
);
   import dcm_pkg::*;

   localparam int AW = W + GUARD;
   localparam int NT = RS_HIST;
   localparam logic signed [AW-1:0] HI = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [AW-1:0] LO = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

   if (W < 4) begin : g_bad_w
      $error("dcm_resamp32: W must be at least 4");
   end

   function automatic logic signed [AW-1:0] sx(input logic [W-1:0] v);
      return AW'($signed(v));
   endfunction

   function automatic logic [W-1:0] clip(input logic signed [AW-1:0] v);
      if (v > HI)      return HI[W-1:0];
      else if (v < LO) return LO[W-1:0];
      else             return v[W-1:0];
   endfunction

   // late selects the second branch: heavy weight on x[n-2] instead of x[n-1]
   function automatic logic [W-1:0] rs_calc(input logic [W-1:0] x0, input logic [W-1:0] x1,
                                            input logic [W-1:0] x2, input logic [W-1:0] x3,
                                            input logic late);
      logic signed [AW-1:0] near, far, acc;
      near = late ? sx(x2) : sx(x1);
      far  = late ? sx(x1) : sx(x2);
      acc  = (sx(x0) <<< 1) + (near <<< 3) + (near <<< 2) + (far <<< 3) + (sx(x3) <<< 1);
      return clip(acc >>> 4);
   endfunction

   logic [NCH-1:0][NT-1:0][W-1:0] tap_q;
   logic [1:0]                    ph_q;
   logic                          vld_q;
   logic [NCH-1:0][W-1:0]         dat_q;
   logic [NCH-1:0][W-1:0]         res;

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         res[c] = rs_calc(in_d[c], tap_q[c][0], tap_q[c][1], tap_q[c][2], ph_q[1]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         tap_q <= '0;
         ph_q  <= 2'd0;
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (en && in_vld) begin
         for (int c = 0; c < NCH; c++) begin
            tap_q[c] <= {tap_q[c][NT-2:0], in_d[c]};
         end
         ph_q  <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
         vld_q <= (ph_q != 2'd0);
         if (ph_q != 2'd0) dat_q <= res;
      end else begin
         vld_q <= 1'b0;
      end
   end

   assign out_vld = en ? vld_q : in_vld;
   assign out_d   = en ? dat_q : in_d;

   assert_rs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(vld_q)) |=> !vld_q);
   assert_rs_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q != 2'd3);

endmodule

// File: rtl/dcm_gain.sv
module dcm_gain #(
   parameter int W   = 12,
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic                    scale,
   input  logic                    in_vld,
   input  logic [NCH-1:0][W-1:0]   in_d,
   output logic                    out_vld,
   output logic [NCH-1:0][W-1:0]   out_d
);
   import dcm_pkg::*;

   localparam int AW = W + GUARD;
   localparam logic signed [AW-1:0] HI = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [AW-1:0] LO = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

   if (W < 4) begin : g_bad_w
      $error("dcm_gain: W must be at least 4");
   end

   function automatic logic [W-1:0] clip(input logic signed [AW-1:0] v);
      if (v > HI)      return HI[W-1:0];
      else if (v < LO) return LO[W-1:0];
      else             return v[W-1:0];
   endfunction

   // 11/16 undoes most of the resampler's 3/2 gain
   function automatic logic [W-1:0] trim(input logic [W-1:0] v);
      logic signed [AW-1:0] e, p;
      e = AW'($signed(v));
      p = (e <<< 3) + (e <<< 1) + e;
      return clip(p >>> 4);
   endfunction

   logic                  vld_q;
   logic [NCH-1:0][W-1:0] dat_q;
   logic [NCH-1:0][W-1:0] res;

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         res[c] = scale ? trim(in_d[c]) : in_d[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) dat_q <= res;
      end
   end

   assign out_vld = vld_q;
   assign out_d   = dat_q;

endmodule

// File: rtl/dcm_chain.sv
module dcm_chain #(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          mode,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_i,
   input  logic signed [W-1:0] in_q,
   output logic                out_valid,
   output logic signed [W-1:0] out_i,
   output logic signed [W-1:0] out_q
);
   import dcm_pkg::*;

   localparam int NCH = NLANE;
   localparam int NST = 4;   // dropper, two half-bands, resampler

   if (W < 4 || W > 24) begin : g_bad_w
      $error("dcm_chain: W must lie in 4..24");
   end

   logic [2:0]            mode_q;
   logic                  flush;
   stage_en_t             en;
   logic [1:0]            hb_en;
   logic [NST:0]          vld_c;
   logic [NCH-1:0][W-1:0] dat_c [NST+1];
   logic [NCH-1:0][W-1:0] res_d;
   logic                  res_v;

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= 3'd0;
      else        mode_q <= mode;
   end

   assign flush    = (mode != mode_q);
   assign en       = decode_mode(mode_q);
   assign hb_en    = {en.hb_b, en.hb_a};
   assign vld_c[0] = in_valid && !flush;
   assign dat_c[0] = {in_q, in_i};

   dcm_drop2 #(.W(W), .NCH(NCH)) u_drop (
      .clk(clk), .rst_n(rst_n), .en(en.drop), .flush(flush),
      .in_vld(vld_c[0]), .in_d(dat_c[0]), .out_vld(vld_c[1]), .out_d(dat_c[1]));

   for (genvar g = 0; g < 2; g++) begin : g_hb
      dcm_halfband #(.W(W), .NCH(NCH)) u_hb (
         .clk(clk), .rst_n(rst_n), .en(hb_en[g]), .flush(flush),
         .in_vld(vld_c[g+1]), .in_d(dat_c[g+1]),
         .out_vld(vld_c[g+2]), .out_d(dat_c[g+2]));
   end

   dcm_resamp32 #(.W(W), .NCH(NCH)) u_rs (
      .clk(clk), .rst_n(rst_n), .en(en.rs), .flush(flush),
      .in_vld(vld_c[3]), .in_d(dat_c[3]), .out_vld(vld_c[4]), .out_d(dat_c[4]));

   dcm_gain #(.W(W), .NCH(NCH)) u_gain (
      .clk(clk), .rst_n(rst_n), .flush(flush), .scale(en.rs),
      .in_vld(vld_c[NST]), .in_d(dat_c[NST]), .out_vld(res_v), .out_d(res_d));

   assign out_valid = res_v;
   assign out_i     = $signed(res_d[0]);
   assign out_q     = $signed(res_d[1]);

   assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);
   assert_bypass_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 3'd0 && !flush) |=> (out_valid == $past(in_valid)));
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

// File: tb/test_dcm_chain.sv
module test_dcm_chain;
   localparam int W  = 12;
   localparam int HI = (1 << (W-1)) - 1;
   localparam int LO = -(1 << (W-1));

   typedef int iq_t[$];

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [2:0]          mode = 3'd0;
   logic                in_valid = 1'b0;
   logic signed [W-1:0] in_i = '0;
   logic signed [W-1:0] in_q = '0;
   logic                out_valid;
   logic signed [W-1:0] out_i;
   logic signed [W-1:0] out_q;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   iq_t got_i, got_q, src_i, src_q;

   always #5 clk = ~clk;

   dcm_chain #(.W(W)) i_dcm_chain (
      .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
      .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         got_i.push_back(int'(out_i));
         got_q.push_back(int'(out_q));
      end
   end

   function automatic int sat(input int v);
      if (v > HI) return HI;
      if (v < LO) return LO;
      return v;
   endfunction

   function automatic iq_t m_drop(input iq_t x);
      iq_t y;
      foreach (x[k]) if (k % 2 == 0) y.push_back(x[k]);
      return y;
   endfunction

   function automatic iq_t m_hb(input iq_t x);
      iq_t y;
      int h[7];
      foreach (h[j]) h[j] = 0;
      foreach (x[k]) begin
         for (int j = 6; j > 0; j--) h[j] = h[j-1];
         h[0] = x[k];
         if (k % 2 == 1) y.push_back(sat((16*h[3] + 9*(h[2]+h[4]) - h[0] - h[6]) >>> 5));
      end
      return y;
   endfunction

   function automatic iq_t m_rs(input iq_t x);
      iq_t y;
      int h[4];
      foreach (h[j]) h[j] = 0;
      foreach (x[k]) begin
         for (int j = 3; j > 0; j--) h[j] = h[j-1];
         h[0] = x[k];
         if (k % 3 == 1) y.push_back(sat((2*h[0] + 12*h[1] + 8*h[2] + 2*h[3]) >>> 4));
         if (k % 3 == 2) y.push_back(sat((2*h[0] + 8*h[1] + 12*h[2] + 2*h[3]) >>> 4));
      end
      return y;
   endfunction

   // stage usage per ratio code, written from R2
   function automatic iq_t model(input iq_t x, input int m);
      iq_t y;
      bit d, a, b, r;
      d = (m == 5 || m == 6);
      a = (m >= 2 && m <= 6);
      b = (m == 4 || m == 6);
      r = (m == 1 || m == 3 || m == 5);
      y = x;
      if (d) y = m_drop(y);
      if (a) y = m_hb(y);
      if (b) y = m_hb(y);
      if (r) begin
         y = m_rs(y);
         foreach (y[k]) y[k] = sat((y[k] * 11) >>> 4);
      end
      return y;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_mode(input int m);
      @(posedge clk); #1;
      mode = 3'(m);
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      got_i.delete(); got_q.delete();
      src_i.delete(); src_q.delete();
   endtask

   task automatic push(input int vi, input int vq, input bit gaps);
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_i = W'(vi); in_q = W'(vq);
      src_i.push_back(vi); src_q.push_back(vq);
      if (gaps && ($urandom % 3 == 0)) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   task automatic finish_run(input int m, input string req);
      iq_t ei, eq;
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (20) @(posedge clk);
      #1;
      ei = model(src_i, m);
      eq = model(src_q, m);
      chk(got_i.size() == ei.size(), {req, " R2 count"}, got_i.size(), ei.size());
      for (int k = 0; k < ei.size() && k < got_i.size(); k++) begin
         chk(got_i[k] == ei[k], {req, " R10 lane I"}, got_i[k], ei[k]);
         chk(got_q[k] == eq[k], {req, " R10 lane Q"}, got_q[k], eq[k]);
      end
   endtask

   task automatic rand_run(input int m, input int n, input string req);
      set_mode(m);
      for (int k = 0; k < n; k++) begin
         push(int'($urandom % (1 << W)) + LO, int'($urandom % (1 << W)) + LO, 1'b1);
      end
      finish_run(m, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) @(posedge clk);
      #1; chk(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #4;
      chk(out_valid == 1'b0, "R1 after release", int'(out_valid), 0);

      // R7: full bypass reproduces input
      rand_run(0, 40, "R7 code0");
      rand_run(7, 30, "R2 code7");
      // R5, R6: resampler and gain
      rand_run(1, 60, "R5 R6 code1");
      // R4: half-band
      rand_run(2, 60, "R4 code2");
      rand_run(3, 90, "R4 R5 code3");
      rand_run(4, 80, "R4 code4");
      // R3: dropper ahead of filters
      rand_run(5, 120, "R3 code5");
      rand_run(6, 128, "R3 code6");

      // R9: saturation corners, alternating and constant full scale
      set_mode(1);
      for (int k = 0; k < 12; k++) push(HI, LO, 1'b0);
      finish_run(1, "R9 rs const");
      set_mode(2);
      for (int k = 0; k < 16; k++) push((k % 2) ? LO : HI, (k % 2) ? HI : LO, 1'b0);
      finish_run(2, "R9 hb alt");
      set_mode(4);
      for (int k = 0; k < 24; k++) push(((k / 2) % 2) ? LO : HI, LO, 1'b0);
      finish_run(4, "R9 hb pair");
      set_mode(3);
      for (int k = 0; k < 18; k++) push((k % 3 == 0) ? LO : HI, HI, 1'b0);
      finish_run(3, "R9 hb rs");

      // R8: odd-length burst leaves state, mode change must clear it
      for (int rep = 0; rep < 3; rep++) begin
         set_mode(6);
         for (int k = 0; k < 7; k++) push(HI - k, LO + k, 1'b0);
         set_mode(3);
         for (int k = 0; k < 5; k++) push(LO + 3*k, HI - 5*k, 1'b0);
         set_mode(5);
         for (int k = 0; k < 36; k++) push(int'($urandom % 400) - 200, int'($urandom % 400) - 200, 1'b1);
         finish_run(5, "R8 flush");
      end

      // R8: a sample arriving with the mode change is discarded
      set_mode(0);
      @(posedge clk); #1;
      mode = 3'd7;
      in_valid = 1'b1; in_i = W'(77); in_q = W'(-5);
      @(posedge clk); #1;
      in_valid = 1'b0;
      repeat (6) @(posedge clk);
      #1;
      chk(got_i.size() == 0, "R8 discard", got_i.size(), 0);

      // R2: one more random pass over every code
      for (int m = 0; m < 8; m++) rand_run(m, 48, "R2 sweep");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule